// File: doc/BRIEF.md
# Clocked Serial Shift Port

A byte-wide synchronous serial link port. Software sees two registers: a data byte and a control byte. Writing the control byte with its start bit set starts an eight-bit exchange. On every bit period the data byte shifts one place toward its most significant end. The bit on the serial input enters at the bottom, and the bit that leaves at the top has already been driven on the serial output. After the eighth bit the start bit clears and a one-cycle interrupt request is raised.

The bit clock has two sources. With the internal clock selected, a down-counter advances on the `tick` enable and moves one bit each time it expires. It expires after 512 ticks, or after 16 ticks when the fast-rate bit is set and the port is in high-speed-capable mode. With the external clock selected, the counter plays no part and each one-cycle pulse on `ext_clk` moves one bit. A control write during a transfer re-chooses the clock and restarts the period count, but keeps the number of bits still to go.

Top module: `link_shift_port`

## Requirements
- R1: Writing the control register (`reg_sel`=1) with bit 7 set while idle starts an exchange of exactly 8 bits. The control read-back keeps bit 7 at 1 until the exchange ends.
- R2: With control bit 0 = 1, one bit moves on the 512th `tick` after the start, and then every 512 ticks. If control bit 1 is also set and `fast_mode` is 1, this happens on the 16th tick instead.
- R3: With control bit 0 = 0, `tick` never moves a bit and each `ext_clk` pulse moves exactly one. With control bit 0 = 1, `ext_clk` is ignored.
- R4: Each bit step sets the data register to {data[6:0], ser_in}. `ser_out` always equals data bit 7.
- R5: The step that moves the 8th bit clears control bit 7 and returns the port to idle. In the next cycle `irq` is 1 for exactly one cycle.
- R6: A control write during an exchange does not restart the exchange, even with bit 7 set. It only reselects the clock from the new bit 0 and reloads the period count, and the remaining bit count is kept.
- R7: Control read-back equals 0x7C | (written & 0x83) when `fast_mode` was 1 at the write, and 0x7E | (written & 0x81) otherwise.
- R8: After reset, control reads 0x7E, data reads 0x00, `ser_out` is 0 and `irq` is 0.
- R9: A data write (`reg_sel`=0) replaces the data register, and reading with `reg_sel`=0 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | High-speed-capable mode: allows the 16-tick period and bit 1 read-back |
| reg_sel | input | 1 | Register select: 0 data, 1 control |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write value |
| rd_data | output | 8 | Read value of the selected register |
| tick | input | 1 | Timebase enable for the internal bit clock |
| ext_clk | input | 1 | One-cycle external bit clock pulse |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out |
| irq | output | 1 | One-cycle transfer-complete interrupt request |

## Verification
The bench places ticks exactly on each side of the 512- and 16-tick boundaries. A counter that is off by one, or that picks the fast rate without `fast_mode`, shows up there as a shift one tick early or late. It switches the clock source in the middle of an exchange and counts the bits that follow. A design that restarts on a busy control write asks for eight more bits, and one that does not reload the counter shifts early. It sweeps every control value with the start bit clear in both modes, which exposes a wrong read-back mask. It also checks that pulses from the unselected clock leave the data untouched and that the interrupt lasts exactly one cycle.

// File: rtl/link_shift_port.sv
module link_shift_port #(
  parameter int SLOW_PERIOD = 512,
  parameter int FAST_PERIOD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tick,
  input  logic       ext_clk,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       irq
);
  localparam int CW = $clog2(SLOW_PERIOD + 1);
  localparam int NBITS = 8;

  logic [7:0]    data_q, ctrl_q;
  logic          busy_q, int_q, irq_q;
  logic [3:0]    left_q;
  logic [CW-1:0] cnt_q, per_q;

  wire ctrl_wr = wr_en & reg_sel;
  wire data_wr = wr_en & ~reg_sel;
  wire [CW-1:0] new_per = (wr_data[1] & fast_mode) ? CW'(FAST_PERIOD) : CW'(SLOW_PERIOD);
  wire step = busy_q & ~wr_en & (int_q ? (tick & (cnt_q == CW'(1))) : ext_clk);
  wire last = step & (left_q == 4'd1);

  assign rd_data = reg_sel ? ctrl_q : data_q;
  assign ser_out = data_q[7];
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= 8'h00;
      ctrl_q <= 8'h7E;
      busy_q <= 1'b0;
      int_q  <= 1'b0;
      irq_q  <= 1'b0;
      left_q <= 4'd0;
      cnt_q  <= '0;
      per_q  <= CW'(SLOW_PERIOD);
    end else begin
      irq_q <= last;
      if (ctrl_wr) begin
        ctrl_q <= fast_mode ? (8'h7C | (wr_data & 8'h83)) : (8'h7E | (wr_data & 8'h81));
        if (busy_q || wr_data[7]) begin
          int_q <= wr_data[0];
          per_q <= new_per;
          cnt_q <= new_per;
        end
        if (!busy_q && wr_data[7]) begin
          busy_q <= 1'b1;
          left_q <= 4'(NBITS);
        end
      end else if (data_wr) begin
        data_q <= wr_data;
      end else if (busy_q && int_q && tick) begin
        cnt_q <= step ? per_q : cnt_q - CW'(1);
      end
      if (step) begin
        data_q <= {data_q[6:0], ser_in};
        left_q <= left_q - 4'd1;
        if (last) begin
          busy_q    <= 1'b0;
          ctrl_q[7] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/link_shift_port_chk.sv
module link_shift_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       tick,
  input logic       ext_clk,
  input logic       irq,
  input logic       busy,
  input logic       int_sel,
  input logic [3:0] left,
  input logic [7:0] data,
  input logic [7:0] ctrl
);
  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n) left <= 4'd8); // R1
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (!busy && !ctrl[7])); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R5
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !int_sel && !ext_clk && !wr_en) |=> ($stable(data) && $stable(left))); // R3
  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int_sel && !tick && !wr_en) |=> ($stable(data) && $stable(left))); // R2
  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n) ctrl[6:2] == 5'h1F); // R7
endmodule

bind link_shift_port link_shift_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .ext_clk(ext_clk),
  .irq(irq), .busy(busy_q), .int_sel(int_q), .left(left_q), .data(data_q), .ctrl(ctrl_q)
);

// File: tb/test_link_shift_port.sv
module test_link_shift_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, fast_mode = 0, reg_sel = 0, wr_en = 0;
  logic tick = 0, ext_clk = 0, ser_in = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic ser_out, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_shift_port i_link_shift_port (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick(tick), .ext_clk(ext_clk),
    .ser_in(ser_in), .ser_out(ser_out), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] v);
    reg_sel = sel; wr_data = v; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic sel, output logic [7:0] v);
    reg_sel = sel; #1; v = rd_data;
  endtask

  task automatic ticks(int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic ext_pulse();
    ext_clk = 1; @(negedge clk); ext_clk = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=00 expected=01");
    finish_run();
  end

  initial begin
    logic [7:0] v, exp, s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset values
    rd(1, v); check("R8 ctrl", v, 8'h7E);
    rd(0, v); check("R8 data", v, 8'h00);
    check("R8 ser_out", {7'd0, ser_out}, 8'h00);
    check("R8 irq", {7'd0, irq}, 8'h00);

    // R7 mask sweep, start bit clear
    for (int m = 0; m < 2; m++) begin
      fast_mode = m[0];
      for (int x = 0; x < 128; x++) begin
        wr(1, 8'(x));
        rd(1, v);
        check("R7 mask", v, m ? (8'h7C | (8'(x) & 8'h83)) : (8'h7E | (8'(x) & 8'h81)));
      end
    end

    // R9 data write
    wr(0, 8'h3C); rd(0, v); check("R9 data", v, 8'h3C);

    // R2 slow period even with bit 1 set, R4 shifting, R1, R5
    fast_mode = 0; s = 8'h96; exp = 8'h3C;
    wr(1, 8'h83);
    rd(1, v); check("R1 busy ctrl", v, 8'hFF);
    for (int k = 0; k < 8; k++) begin
      ser_in = s[7-k];
      check("R4 ser_out", {7'd0, ser_out}, {7'd0, exp[7]});
      ticks(511);
      if (k == 0) begin rd(0, v); check("R2 slow early", v, exp); end
      ticks(1);
      exp = {exp[6:0], s[7-k]};
      rd(0, v); check("R4 shift", v, exp);
      if (k < 7) check("R5 no early irq", {7'd0, irq}, 8'h00);
    end
    check("R5 irq", {7'd0, irq}, 8'h01);
    rd(1, v); check("R5 start clear", v, 8'h7F);
    @(negedge clk);
    check("R5 irq pulse", {7'd0, irq}, 8'h00);

    // R2 fast period sweep
    fast_mode = 1;
    for (int p = 0; p < 16; p++) begin
      exp = 8'(p * 17) ^ 8'h5A; s = 8'(p * 29 + 3);
      wr(0, exp);
      wr(1, 8'h83);
      for (int k = 0; k < 8; k++) begin
        ser_in = s[7-k];
        check("R4 ser_out fast", {7'd0, ser_out}, {7'd0, exp[7]});
        ticks(15);
        rd(0, v); check("R2 fast early", v, exp);
        ticks(1);
        exp = {exp[6:0], s[7-k]};
        rd(0, v); check("R2 fast shift", v, exp);
      end
      check("R5 irq fast", {7'd0, irq}, 8'h01);
      rd(1, v); check("R7 ctrl fast done", v, 8'h7F);
      @(negedge clk);
    end

    // R3 external clock
    fast_mode = 0; ser_in = 1;
    wr(0, 8'h00);
    wr(1, 8'h80);
    ticks(600);
    rd(0, v); check("R3 tick ignored", v, 8'h00);
    exp = 8'h00;
    for (int k = 0; k < 8; k++) begin
      ser_in = k[0];
      ext_pulse();
      exp = {exp[6:0], k[0]};
      rd(0, v); check("R3 ext step", v, exp);
    end
    check("R5 irq ext", {7'd0, irq}, 8'h01);
    @(negedge clk);

    // R3 ext ignored under internal, R6 reconfiguration mid-transfer
    wr(0, 8'hC3); exp = 8'hC3;
    wr(1, 8'h81);
    repeat (5) ext_pulse();
    rd(0, v); check("R3 ext ignored", v, 8'hC3);
    ticks(300);
    wr(1, 8'h80);
    ticks(1000);
    rd(0, v); check("R6 now external", v, 8'hC3);
    ser_in = 0;
    for (int k = 0; k < 3; k++) begin ext_pulse(); exp = {exp[6:0], 1'b0}; end
    rd(0, v); check("R6 three bits", v, exp);
    wr(1, 8'h81);
    ser_in = 1;
    for (int k = 0; k < 5; k++) begin
      ticks(511);
      rd(0, v); check("R6 reload early", v, exp);
      ticks(1);
      exp = {exp[6:0], 1'b1};
      rd(0, v); check("R6 shift", v, exp);
      check("R6 irq timing", {7'd0, irq}, (k == 4) ? 8'h01 : 8'h00);
    end
    @(negedge clk);
    check("R5 irq drop", {7'd0, irq}, 8'h00);
    finish_run();
  end
endmodule